// File: doc/BRIEF.md
# Snoop-unit control register bank

This block is the software-visible register bank of the coherency (snoop) unit in a small multiprocessor cluster. It sits behind a simple bus slave port that decodes a byte offset inside a 256-byte window. Each access carries a transfer size of 1, 2 or 4 bytes. The bank holds three things: an enable-style control bit, a read-only configuration word built from the CPU-count parameter, and a 32-bit power-status word with one byte per CPU.

The power-status word may be accessed at any of its four byte addresses. A read at byte lane k returns the word shifted down by k bytes. A write at lane k replaces only the bytes covered by the transfer size, starting at lane k. Any bytes that would fall past the top of the word are dropped. A write with a size other than 1, 2 or 4 is thrown away. The invalidate, filtering and access-control locations, and every unmapped offset, read as zero and ignore writes. No cache or coherency action is modelled.

Read data is registered. It appears on the clock after the read strobe and holds until the next read. The CPU count must lie between 1 and 4.

Top module: `scu_regbank`

## Requirements
- R1: A write to offset 0x00 stores only bit 0 of the write data and clears every other bit. A read of 0x00 returns the stored value.
- R2: A read of offset 0x04 returns ((2^NUM_CPU - 1) << 4) | (NUM_CPU - 1). This is 0x31 for the default of two CPUs. Writes to 0x04 change nothing.
- R3: A read at offset 0x08+k (k = 0..3) returns the power-status word shifted right by 8*k bits, with zeros filled in from the top.
- R4: A write at offset 0x08+k with size s (1, 2 or 4) replaces the bytes k through k+s-1 of the power-status word with the low s bytes of the write data. Bytes above byte 3 are dropped, and the other bytes keep their value.
- R5: A write whose size code is not 1, 2 or 4 changes neither the control register nor the power-status word.
- R6: Offsets 0x0C, 0x40, 0x44, 0x50, 0x54 and every other offset not named in R1 to R4 read as zero. Writes to them change no stored state.
- R7: A synchronous reset clears the control register, the power-status word and the read data to zero.
- R8: Read data changes only on the clock edge that samples the read strobe, and holds otherwise. A read sampled on the same edge as a write returns the value from before that write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 8 | Byte offset inside the 256-byte window |
| wr_en | input | 1 | Write strobe, one access per sampled cycle |
| rd_en | input | 1 | Read strobe, one access per sampled cycle |
| size | input | 3 | Transfer size in bytes: 1, 2 or 4 are valid |
| wdata | input | 32 | Write data, right-aligned |
| rdata | output | 32 | Registered read data |

## Verification
The assertions assume that every input is known whenever reset is low, and that a write carrying a valid size is a complete access in a single cycle. The stimulus holds the strobes low outside its access tasks. It changes inputs only on the falling clock edge and drives each strobe for exactly one cycle. Invalid size codes, overlapping read and write strobes, and a reset in the middle of a run are all produced on purpose, so the properties about discarded writes and held read data are actually exercised rather than holding vacuously.

// File: rtl/scu_bank_pkg.sv
package scu_bank_pkg;

  localparam int DATA_W = 32;
  localparam int ADDR_W = 8;
  localparam int SIZE_W = 3;
  localparam int NBYTES = DATA_W / 8;
  localparam int LANE_W = $clog2(NBYTES);

  // decoded byte offsets whose behaviour depends on position
  localparam logic [ADDR_W-1:0] OFS_CTRL = 8'h00;
  localparam logic [ADDR_W-1:0] OFS_CFG  = 8'h04;
  localparam logic [ADDR_W-1:0] OFS_PWR  = 8'h08;

  typedef enum logic [1:0] {
    SEL_NONE,
    SEL_CTRL,
    SEL_CFG,
    SEL_PWR
  } reg_sel_e;

  function automatic logic size_ok(input logic [SIZE_W-1:0] sz);
    return (sz == 3'd1) || (sz == 3'd2) || (sz == 3'd4);
  endfunction

  function automatic reg_sel_e decode(input logic [ADDR_W-1:0] a);
    if (a == OFS_CTRL)                          return SEL_CTRL;
    if (a == OFS_CFG)                           return SEL_CFG;
    if (a[ADDR_W-1:LANE_W] == OFS_PWR[ADDR_W-1:LANE_W]) return SEL_PWR;
    return SEL_NONE;
  endfunction

endpackage

// File: rtl/scu_lane_mask.sv
module scu_lane_mask
  import scu_bank_pkg::*;
#(
  parameter int NB = NBYTES
) (
  input  logic [SIZE_W-1:0]       size,
  input  logic [$clog2(NB)-1:0]   lane,
  output logic                    valid,
  output logic [8*NB-1:0]         mask
);

  logic [SIZE_W-1:0] nbytes;

  assign valid  = size_ok(size);
  assign nbytes = valid ? size : '0;

  // each byte lane is enabled when it lies in [lane, lane+nbytes); lanes past
  // the top of the word simply do not exist, so overflow drops naturally
  for (genvar b = 0; b < NB; b++) begin : g_lane
    logic hit;
    assign hit = (int'(lane) <= b) && ((b - int'(lane)) < int'(nbytes));
    assign mask[8*b +: 8] = {8{hit}};
  end

endmodule

// File: rtl/scu_pwr_word.sv
module scu_pwr_word
  import scu_bank_pkg::*;
#(
  parameter int DW = DATA_W
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      we,
  input  logic [$clog2(DW/8)-1:0]   lane,
  input  logic [SIZE_W-1:0]         size,
  input  logic [DW-1:0]             wdata,
  output logic [DW-1:0]             word
);

  localparam int NB  = DW / 8;
  localparam int LW  = $clog2(NB);

  logic          valid;
  logic [DW-1:0] mask;
  logic [DW-1:0] shifted;
  logic [DW-1:0] word_q;

  scu_lane_mask #(.NB(NB)) u_mask (
    .size  (size),
    .lane  (lane),
    .valid (valid),
    .mask  (mask)
  );

  assign shifted = wdata << {lane, 3'b000};

  always_ff @(posedge clk) begin
    if (rst) begin
      word_q <= '0;
    end else if (we && valid) begin
      word_q <= (word_q & ~mask) | (shifted & mask);
    end
  end

  assign word = word_q;

  // bytes outside the addressed window must survive a write
  AST_PWR_KEEP_UNMASKED: assert property (@(posedge clk) disable iff (rst)
    (we && valid) |=> ((word_q & ~$past(mask)) == ($past(word_q) & ~$past(mask)))); // R4

  // bytes inside the window take the shifted write data
  AST_PWR_TAKE_MASKED: assert property (@(posedge clk) disable iff (rst)
    (we && valid) |=> ((word_q & $past(mask)) == ($past(wdata << {lane, 3'b000}) & $past(mask)))); // R4

  // an illegal size leaves the word untouched
  AST_PWR_BAD_SIZE: assert property (@(posedge clk) disable iff (rst)
    (we && !size_ok(size)) |=> $stable(word_q)); // R5

  // a size-1 write can never touch more than one byte
  AST_PWR_ONE_BYTE: assert property (@(posedge clk) disable iff (rst)
    (we && size == 3'd1) |=> ($countones($past(word_q) ^ word_q) <= 8)); // R4

  logic unused_lw;
  assign unused_lw = (LW > 0);

endmodule

// File: rtl/scu_read_port.sv
module scu_read_port
  import scu_bank_pkg::*;
#(
  parameter int NUM_CPU = 2,
  parameter int DW      = DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic              ctrl_bit,
  input  logic [DW-1:0]     pwr_word,
  output logic [DW-1:0]     rdata
);

  localparam int CNT_W = 4;
  localparam logic [DW-1:0] PRESENT = DW'(((1 << NUM_CPU) - 1) << 4);
  localparam logic [DW-1:0] CFG_VAL = PRESENT | DW'(NUM_CPU - 1);

  reg_sel_e      sel;
  logic [DW-1:0] rd_next;
  logic [DW-1:0] rdata_q;

  assign sel = decode(addr);

  always_comb begin
    unique case (sel)
      SEL_CTRL: rd_next = {{(DW-1){1'b0}}, ctrl_bit};
      SEL_CFG:  rd_next = CFG_VAL;
      SEL_PWR:  rd_next = pwr_word >> {addr[LANE_W-1:0], 3'b000};
      default:  rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata_q <= '0;
    else if (rd_en) rdata_q <= rd_next;
  end

  assign rdata = rdata_q;

  AST_RD_HOLD: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rdata_q)); // R8

  AST_CFG_VALUE: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == OFS_CFG) |=> (rdata_q[3:0] == CNT_W'(NUM_CPU - 1))); // R2

  AST_CTRL_ONE_BIT: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == OFS_CTRL) |=> (rdata_q[DW-1:1] == '0)); // R1

  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rd_en && decode(addr) == SEL_NONE) |=> (rdata_q == '0)); // R6

  AST_PWR_TOP_FILL: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == 8'h0B) |=> (rdata_q[DW-1:8] == '0)); // R3

endmodule

// File: rtl/scu_regbank.sv
module scu_regbank
  import scu_bank_pkg::*;
#(
  parameter int NUM_CPU = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [7:0]        addr,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [2:0]        size,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata
);

  reg_sel_e    wsel;
  logic        wr_ok;
  logic        ctrl_q;
  logic        pwr_we;
  logic [31:0] pwr_word;

  assign wsel   = decode(addr);
  assign wr_ok  = wr_en && size_ok(size);
  assign pwr_we = wr_en && (wsel == SEL_PWR);

  always_ff @(posedge clk) begin
    if (rst)                              ctrl_q <= 1'b0;
    else if (wr_ok && wsel == SEL_CTRL)   ctrl_q <= wdata[0];
  end

  scu_pwr_word #(.DW(DATA_W)) u_pwr (
    .clk   (clk),
    .rst   (rst),
    .we    (pwr_we),
    .lane  (addr[LANE_W-1:0]),
    .size  (size),
    .wdata (wdata),
    .word  (pwr_word)
  );

  scu_read_port #(.NUM_CPU(NUM_CPU), .DW(DATA_W)) u_rd (
    .clk      (clk),
    .rst      (rst),
    .rd_en    (rd_en),
    .addr     (addr),
    .ctrl_bit (ctrl_q),
    .pwr_word (pwr_word),
    .rdata    (rdata)
  );

  AST_CTRL_BAD_SIZE: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !size_ok(size)) |=> $stable(ctrl_q)); // R5

  AST_CTRL_OTHER_ADDR: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr != OFS_CTRL) |=> $stable(ctrl_q)); // R6

  AST_PWR_OTHER_ADDR: assert property (@(posedge clk) disable iff (rst)
    (wr_en && decode(addr) != SEL_PWR) |=> $stable(pwr_word)); // R6

  AST_CTRL_WRITE: assert property (@(posedge clk) disable iff (rst)
    (wr_ok && addr == OFS_CTRL) |=> (ctrl_q == $past(wdata[0]))); // R1

endmodule

// File: tb/scu_regbank_test.sv
module scu_regbank_test;

  localparam int NUM_CPU = 2;
  localparam logic [31:0] CFG = (((32'd1 << NUM_CPU) - 1) << 4) | (NUM_CPU - 1);
  localparam logic W = 1'b1;
  localparam logic R = 1'b0;
  localparam int NV = 44;

  // {req[3:0], op, addr[7:0], size[2:0], wdata[31:0], expected[31:0]}
  localparam logic [79:0] VECS [0:NV-1] = '{
    {4'd1, R, 8'h00, 3'd4, 32'h0, 32'h0},               // R1 after reset
    {4'd2, R, 8'h04, 3'd4, 32'h0, CFG},                 // R2
    {4'd1, W, 8'h00, 3'd4, 32'hFFFFFFFF, 32'h0},
    {4'd1, R, 8'h00, 3'd4, 32'h0, 32'h1},               // R1 only bit 0 kept
    {4'd1, W, 8'h00, 3'd1, 32'hFFFFFFFE, 32'h0},
    {4'd1, R, 8'h00, 3'd4, 32'h0, 32'h0},               // R1 cleared
    {4'd2, W, 8'h04, 3'd4, 32'hFFFFFFFF, 32'h0},
    {4'd2, R, 8'h04, 3'd4, 32'h0, CFG},                 // R2 write ignored
    {4'd4, W, 8'h08, 3'd4, 32'h11223344, 32'h0},
    {4'd3, R, 8'h08, 3'd4, 32'h0, 32'h11223344},        // R3 lane 0
    {4'd3, R, 8'h09, 3'd4, 32'h0, 32'h00112233},        // R3 lane 1
    {4'd3, R, 8'h0A, 3'd4, 32'h0, 32'h00001122},        // R3 lane 2
    {4'd3, R, 8'h0B, 3'd4, 32'h0, 32'h00000011},        // R3 lane 3
    {4'd4, W, 8'h09, 3'd1, 32'hAAAAAA55, 32'h0},
    {4'd4, R, 8'h08, 3'd4, 32'h0, 32'h11225544},        // R4 byte at lane 1
    {4'd4, W, 8'h0A, 3'd2, 32'h0000BEEF, 32'h0},
    {4'd4, R, 8'h08, 3'd4, 32'h0, 32'hBEEF5544},        // R4 half at lane 2
    {4'd4, W, 8'h0B, 3'd2, 32'h00001234, 32'h0},
    {4'd4, R, 8'h08, 3'd4, 32'h0, 32'h34EF5544},        // R4 overflow dropped
    {4'd4, W, 8'h09, 3'd4, 32'hCAFEF00D, 32'h0},
    {4'd4, R, 8'h08, 3'd4, 32'h0, 32'hFEF00D44},        // R4 word at lane 1
    {4'd6, W, 8'h0C, 3'd4, 32'hFFFFFFFF, 32'h0},
    {4'd6, R, 8'h0C, 3'd4, 32'h0, 32'h0},               // R6
    {4'd6, W, 8'h40, 3'd4, 32'hFFFFFFFF, 32'h0},
    {4'd6, R, 8'h40, 3'd4, 32'h0, 32'h0},               // R6
    {4'd6, W, 8'h44, 3'd4, 32'hFFFFFFFF, 32'h0},
    {4'd6, R, 8'h44, 3'd4, 32'h0, 32'h0},               // R6
    {4'd6, W, 8'h50, 3'd4, 32'hFFFFFFFF, 32'h0},
    {4'd6, R, 8'h50, 3'd4, 32'h0, 32'h0},               // R6
    {4'd6, W, 8'h54, 3'd4, 32'hFFFFFFFF, 32'h0},
    {4'd6, R, 8'h54, 3'd4, 32'h0, 32'h0},               // R6
    {4'd6, W, 8'h01, 3'd1, 32'h000000FF, 32'h0},
    {4'd6, R, 8'h01, 3'd4, 32'h0, 32'h0},               // R6 unmapped
    {4'd6, R, 8'h3C, 3'd4, 32'h0, 32'h0},               // R6 unmapped
    {4'd6, R, 8'h08, 3'd4, 32'h0, 32'hFEF00D44},        // R6 word untouched
    {4'd6, R, 8'h00, 3'd4, 32'h0, 32'h0},               // R6 control untouched
    {4'd5, W, 8'h08, 3'd3, 32'h0, 32'h0},
    {4'd5, R, 8'h08, 3'd4, 32'h0, 32'hFEF00D44},        // R5 size 3
    {4'd5, W, 8'h0A, 3'd0, 32'h0, 32'h0},
    {4'd5, R, 8'h08, 3'd4, 32'h0, 32'hFEF00D44},        // R5 size 0
    {4'd5, W, 8'h00, 3'd7, 32'h1, 32'h0},
    {4'd5, R, 8'h00, 3'd4, 32'h0, 32'h0},               // R5 control kept
    {4'd4, W, 8'h08, 3'd1, 32'hFFFFFF77, 32'h0},
    {4'd4, R, 8'h08, 3'd4, 32'h0, 32'hFEF00D77}         // R4 byte at lane 0
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  addr = '0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [2:0]  size = 3'd4;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;

  int total = 0;
  int fails = 0;

  always #4 clk = ~clk;

  scu_regbank #(.NUM_CPU(NUM_CPU)) uut (
    .clk   (clk),
    .rst   (rst),
    .addr  (addr),
    .wr_en (wr_en),
    .rd_en (rd_en),
    .size  (size),
    .wdata (wdata),
    .rdata (rdata)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %08h expected %08h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [7:0] a, input logic [2:0] s, input logic [31:0] d);
    @(negedge clk);
    addr = a; size = s; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_read(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] got;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R7 rdata after reset", rdata, 32'h0);

    for (int i = 0; i < NV; i++) begin
      if (VECS[i][75]) begin
        do_write(VECS[i][74:67], VECS[i][66:64], VECS[i][63:32]);
      end else begin
        do_read(VECS[i][74:67], got);
        check($sformatf("R%0d vector %0d", VECS[i][79:76], i), got, VECS[i][31:0]);
      end
    end

    // R8: rdata holds while no read is strobed, even across writes
    do_read(8'h04, got);
    do_write(8'h08, 3'd4, 32'h0BADF00D);
    do_write(8'h00, 3'd4, 32'h1);
    @(negedge clk);
    check("R8 hold without read", rdata, CFG);

    // R8: read and write on the same edge returns the old value
    @(negedge clk);
    addr = 8'h08; size = 3'd4; wdata = 32'h5A5A5A5A; wr_en = 1'b1; rd_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
    check("R8 read before write", rdata, 32'h0BADF00D);
    do_read(8'h08, got);
    check("R8 write then applied", got, 32'h5A5A5A5A);

    // R4: size-4 write at lane 3 keeps only one byte
    do_write(8'h0B, 3'd4, 32'hFFFFFF81);
    do_read(8'h08, got);
    check("R4 lane 3 word write", got, 32'h815A5A5A);

    // R7: reset mid-run clears everything
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R7 rdata cleared", rdata, 32'h0);
    do_read(8'h00, got);
    check("R7 control cleared", got, 32'h0);
    do_read(8'h08, got);
    check("R7 power word cleared", got, 32'h0);
    do_read(8'h04, got);
    check("R2 config after reset", got, CFG);

    finish_run();
  end

endmodule